// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing half of a serial non-volatile memory. It watches the two wires of an I2C bus with the system clock and finds START and STOP conditions. It moves bytes in and out most significant bit first, and it pulls SDA low through an open-drain enable whenever it acknowledges a byte or sends a zero. The first byte after START is a control byte. Its top nibble picks one of two address spaces: the main array, or the auxiliary space that holds the protect and security registers. Its next three bits must equal the device's fixed select value, and its last bit picks the direction.

A write transfer carries two address bytes, high byte first, and these load a pointer that both spaces share. Data bytes that follow go out on a write strobe, one per byte, to a separate write buffer. The STOP that closes the transfer is passed on as a commit pulse. Reads fetch bytes from a simple combinational read port addressed by the same pointer. A repeated START after the address bytes turns the transfer into a random read, and master ACKs extend it into a sequential read. While the write sequencer reports busy, the engine does not acknowledge control bytes, so a master can poll for the end of the write.

Top module: `i2c_mem_slave`

## Requirements
- R1: A control byte is accepted only if its bits [7:4] are 1010 (main array, rd_space/wr_space 0) or 1011 (auxiliary space, 1) and its bits [3:1] equal the DEV_SEL parameter (default 000). Bit 0 = 1 selects read. Any other control byte gets no ACK, and the engine ignores the bus until the next START.
- R2: Each accepted received byte (control, address, write data) is acknowledged by holding sda_oe high from the 8th SCL falling edge to the 9th SCL falling edge.
- R3: While busy_i is high, a control byte gets no ACK. Once busy_i is low, the same control byte is acknowledged.
- R4: In a write, the address bytes load the pointer as {high, low}. Each data byte raises wr_valid for one cycle with wr_addr equal to the pointer, and the pointer then advances within its 64-byte page, so the low 6 bits wrap.
- R5: wr_stop pulses for one cycle after a STOP that ends a write containing at least one data byte. It does not pulse for an address-only write or for a write ended by a repeated START.
- R6: A repeated START after the address bytes keeps the pointer. A following read sends rd_data at that pointer MSB first; sda_oe is the inverse of each bit.
- R7: Each master ACK during a read advances the pointer by one, and the next byte comes from the new address.
- R8: A master NACK followed by STOP advances the pointer by one, so a current-address read (control byte with bit 0 = 1 right after START) continues from there.
- R9: In the main array the pointer rolls over from 0x3FFF to 0x0000.
- R10: Both spaces use one pointer. A read in the auxiliary space leaves the pointer where a later main-array read continues.
- R11: A START or STOP at any bit position releases SDA, drops the byte in progress and returns to waiting for a control byte. The pointer is kept.
- R12: After reset, sda_oe, wr_valid and wr_stop are 0 and rd_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw SCL level |
| sda_i | input | 1 | Raw SDA level (wired bus value) |
| busy_i | input | 1 | Write sequencer busy; suppresses control-byte ACK |
| sda_oe | output | 1 | 1 pulls SDA low |
| rd_addr | output | ADDR_W | Shared pointer, read port address |
| rd_space | output | 1 | 0 main array, 1 auxiliary space |
| rd_data | input | 8 | Byte at rd_addr / rd_space |
| wr_valid | output | 1 | One-cycle strobe per received data byte |
| wr_space | output | 1 | Space of the strobed byte |
| wr_addr | output | ADDR_W | Address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_stop | output | 1 | One-cycle commit pulse on STOP after data |

## Verification
Reads are tried at plain addresses, at the top of the main array and in the auxiliary space, with one to four bytes each. This separates a pointer that fails to step, steps twice, or ignores the 14-bit wrap. Control bytes with a wrong select value, a wrong code and a raised busy show whether the acknowledge decision uses all three fields. Writes that cross a page edge, address-only writes and writes cut by a repeated START distinguish page wrapping from linear stepping, and a real commit from a spurious one. A transfer dropped after four bits, followed by current-address reads, shows that an abort keeps the pointer and that NACK plus STOP steps it exactly once.

// File: rtl/i2cs_pkg.sv
// Shared types and constants for the I2C memory slave engine.
// Assumes: control codes are fixed by the bus protocol of the memory.
package i2cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } eng_state_t;

    localparam logic [3:0] CODE_ARRAY = 4'b1010;
    localparam logic [3:0] CODE_AUX   = 4'b1011;
endpackage

// File: rtl/i2cs_busmon.sv
// Bus monitor: synchronises SCL and SDA into the clock domain and
// reports edges of SCL plus START and STOP events.
// Assumes: the system clock is several times faster than SCL; STAGES >= 2.
module i2cs_busmon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_d, sda_d;

    // synchronizer chains plus one history stage, idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    // event decode from current and previous synchronised levels
    always_comb begin
        scl_s    = scl_ff[STAGES-1];
        sda_s    = sda_ff[STAGES-1];
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        start_ev = scl_s & scl_d & sda_d & ~sda_s;
        stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2cs_ptr.sv
// Shared address pointer: loaded from the address bytes, stepped
// linearly on reads (array wrap at ARRAY_AW bits) or inside a page on writes.
// Assumes: load has priority; the step requests never coincide with load.
module i2cs_ptr #(
    parameter int ADDR_W   = 16,
    parameter int ARRAY_AW = 14,
    parameter int PAGE_AW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_seq,
    input  logic              step_page,
    input  logic              wrap_array,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] ARRAY_MASK = ADDR_W'((64'd1 << ARRAY_AW) - 64'd1);

    logic [ADDR_W-1:0] seq_next, page_next;

    // next values for the two stepping modes
    always_comb begin
        seq_next  = wrap_array ? ((ptr + 1'b1) & ARRAY_MASK) : (ptr + 1'b1);
        page_next = {ptr[ADDR_W-1:PAGE_AW], ptr[PAGE_AW-1:0] + 1'b1};
    end

    // pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr <= '0;
        else if (load)      ptr <= load_val;
        else if (step_seq)  ptr <= seq_next;
        else if (step_page) ptr <= page_next;
    end
endmodule

// File: rtl/i2c_mem_slave.sv
// I2C slave protocol engine for a serial memory: control-byte decode,
// address load, write strobes with STOP commit, and current, random and
// sequential reads from a combinational read port.
// Assumes: rd_data is valid in the cycle after rd_addr/rd_space change;
// busy_i comes from the write sequencer in the same clock domain.
module i2c_mem_slave #(
    parameter int         ADDR_W   = 16,
    parameter int         ARRAY_AW = 14,
    parameter int         PAGE_AW  = 6,
    parameter int         STAGES   = 2,
    parameter logic [2:0] DEV_SEL  = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              busy_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_space,
    input  logic [7:0]        rd_data,
    output logic              wr_valid,
    output logic              wr_space,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_stop
);
    import i2cs_pkg::*;

    localparam int AHI_W = ADDR_W - 8;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    eng_state_t        state;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic [AHI_W-1:0]  addr_hi;
    logic              space, is_rd, mack, rd_pend, wr_seen, oe;
    logic              sel_ok, ptr_load, step_seq, step_page;
    logic [ADDR_W-1:0] ptr;

    i2cs_busmon #(.STAGES(STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    i2cs_ptr #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .PAGE_AW(PAGE_AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val({addr_hi, shreg}),
        .step_seq(step_seq), .step_page(step_page), .wrap_array(~space), .ptr(ptr)
    );

    // control-byte match and pointer control requests
    always_comb begin
        sel_ok    = ((shreg[7:4] == CODE_ARRAY) || (shreg[7:4] == CODE_AUX))
                    && (shreg[3:1] == DEV_SEL) && !busy_i;
        ptr_load  = scl_fall && (bitcnt == 4'd8) && (state == ST_ALO);
        step_page = scl_fall && (bitcnt == 4'd8) && (state == ST_WDAT);
        step_seq  = (!start_ev && !stop_ev && scl_rise && (state == ST_RDAT)
                     && (bitcnt == 4'd8) && !sda_s)
                    || (stop_ev && rd_pend);
    end

    // protocol sequencer: bit counting, ACK, transmit and write strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            addr_hi  <= '0;
            space    <= 1'b0;
            is_rd    <= 1'b0;
            mack     <= 1'b0;
            rd_pend  <= 1'b0;
            wr_seen  <= 1'b0;
            oe       <= 1'b0;
            wr_valid <= 1'b0;
            wr_space <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_stop  <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            wr_stop  <= 1'b0;
            if (start_ev) begin
                state   <= ST_CTRL;
                bitcnt  <= '0;
                oe      <= 1'b0;
                rd_pend <= 1'b0;
                wr_seen <= 1'b0;
            end else if (stop_ev) begin
                state   <= ST_IDLE;
                oe      <= 1'b0;
                rd_pend <= 1'b0;
                wr_seen <= 1'b0;
                wr_stop <= wr_seen;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    if (bitcnt < 4'd8 && state != ST_RDAT) shreg <= {shreg[6:0], sda_s};
                    if (bitcnt == 4'd8 && state == ST_RDAT) mack <= ~sda_s;
                    bitcnt <= bitcnt + 4'd1;
                end
                if (scl_fall) begin
                    if (bitcnt == 4'd8) begin
                        unique case (state)
                            ST_CTRL: begin
                                if (sel_ok) begin
                                    oe    <= 1'b1;
                                    space <= shreg[4];
                                    is_rd <= shreg[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                addr_hi <= shreg[AHI_W-1:0];
                                oe      <= 1'b1;
                                state   <= ST_ALO;
                            end
                            ST_ALO: begin
                                oe    <= 1'b1;
                                state <= ST_WDAT;
                            end
                            ST_WDAT: begin
                                oe       <= 1'b1;
                                wr_valid <= 1'b1;
                                wr_data  <= shreg;
                                wr_addr  <= ptr;
                                wr_space <= space;
                                wr_seen  <= 1'b1;
                            end
                            ST_RDAT: oe <= 1'b0;
                            default: oe <= 1'b0;
                        endcase
                    end else if (bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        if ((state == ST_CTRL && is_rd) || (state == ST_RDAT && mack)) begin
                            state <= ST_RDAT;
                            shreg <= rd_data;
                            oe    <= ~rd_data[7];
                        end else if (state == ST_RDAT) begin
                            state   <= ST_IDLE;
                            oe      <= 1'b0;
                            rd_pend <= 1'b1;
                        end else begin
                            if (state == ST_CTRL) state <= ST_AHI;
                            oe <= 1'b0;
                        end
                    end else if (state == ST_RDAT && bitcnt != 4'd0) begin
                        shreg <= {shreg[6:0], 1'b0};
                        oe    <= ~shreg[6];
                    end
                end
            end
        end
    end

    // port mapping of internal state
    always_comb begin
        sda_oe   = oe;
        rd_addr  = ptr;
        rd_space = space;
    end
endmodule

// File: rtl/i2cs_checker.sv
// Protocol checker for the I2C memory slave engine, bound to the top.
// Assumes: synchronous active-low reset; observes ports and bus events.
module i2cs_checker (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_s,
    input logic start_ev,
    input logic stop_ev,
    input logic wr_valid,
    input logic wr_stop
);
    AST_ACK_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);                         // R2
    AST_START_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe);                             // R11
    AST_STOP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);                              // R11
    AST_WR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> sda_oe);                              // R4
    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stop |-> $past(stop_ev));                       // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);                           // R4
endmodule

bind i2c_mem_slave i2cs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
    .start_ev(start_ev), .stop_ev(stop_ev), .wr_valid(wr_valid), .wr_stop(wr_stop)
);

// File: tb/test_i2c_mem_slave.sv
`timescale 1ns/1ps
module test_i2c_mem_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_drv = 1'b1;
    logic        busy = 1'b0;
    logic        sda_oe, rd_space, wr_valid, wr_space, wr_stop;
    logic [15:0] rd_addr, wr_addr;
    logic [7:0]  rd_data, wr_data;
    logic        bus_sda;
    int          nchk = 0, nerr = 0, nwr = 0, nstop = 0;
    logic [15:0] cap_addr [8];
    logic [7:0]  cap_data [8];
    logic        cap_sp   [8];

    always #2.5 clk = ~clk;

    // memory model: array byte = a[7:0]^a[13:8]^5A, aux byte = ~a[7:0]
    function automatic logic [7:0] mdl(input logic sp, input logic [15:0] a);
        return sp ? ~a[7:0] : (a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A);
    endfunction

    assign bus_sda = sda_drv & ~sda_oe;
    assign rd_data = mdl(rd_space, rd_addr);

    i2c_mem_slave i_i2c_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda), .busy_i(busy),
        .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_space(rd_space), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_space(wr_space), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_stop(wr_stop)
    );

    always @(posedge clk) begin
        if (wr_valid && nwr < 8) begin
            cap_addr[nwr] = wr_addr;
            cap_data[nwr] = wr_data;
            cap_sp[nwr]   = wr_space;
            nwr++;
        end
        if (wr_stop) nstop++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wt(5); scl = 1'b1; wt(20);
        sda_drv = 1'b0; wt(20); scl = 1'b0; wt(5);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wt(15); scl = 1'b1; wt(20);
        sda_drv = 1'b1; wt(40);
    endtask

    task automatic put_bit(input logic b);
        wt(5); sda_drv = b; wt(15); scl = 1'b1; wt(20); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        wt(5); sda_drv = 1'b1; wt(15); scl = 1'b1; wt(10);
        ack = !bus_sda; wt(10); scl = 1'b0;
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            wt(5); sda_drv = 1'b1; wt(15); scl = 1'b1; wt(10);
            d[i] = bus_sda; wt(10); scl = 1'b0;
        end
        put_bit(!mack);
    endtask

    function automatic logic [7:0] ctl(input logic sp, input logic [2:0] sel, input logic rd);
        return {(sp ? 4'b1011 : 4'b1010), sel, rd};
    endfunction

    function automatic logic [15:0] nxt(input logic sp, input logic [15:0] a);
        return sp ? a + 16'd1 : ((a + 16'd1) & 16'h3FFF);
    endfunction

    // random (then sequential) read of n bytes; ACK all but the last
    task automatic rd_random(input logic sp, input logic [15:0] a, input int n);
        bit ack;
        logic [7:0] d;
        logic [15:0] ea = a;
        bus_start();
        send_byte(ctl(sp, 3'b000, 1'b0), ack); chk(ack, "R1 ctrl ack", ack, 1);
        send_byte(a[15:8], ack);               chk(ack, "R2 addr hi ack", ack, 1);
        send_byte(a[7:0], ack);                chk(ack, "R2 addr lo ack", ack, 1);
        bus_start();
        send_byte(ctl(sp, 3'b000, 1'b1), ack); chk(ack, "R6 read ctrl ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, d);
            chk(d == mdl(sp, ea), "R6/R7/R9 read data", d, mdl(sp, ea));
            ea = nxt(sp, ea);
        end
        bus_stop();
    endtask

    // current-address read of one byte
    task automatic rd_current(input logic sp, input logic [15:0] ea, input string tag);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(ctl(sp, 3'b000, 1'b1), ack); chk(ack, tag, ack, 1);
        get_byte(1'b0, d);
        chk(d == mdl(sp, ea), tag, d, mdl(sp, ea));
        bus_stop();
    endtask

    // {space, address, byte count}
    localparam logic [20:0] VEC [5] = '{
        {1'b0, 16'h0000, 4'd1},
        {1'b0, 16'h1234, 4'd3},
        {1'b0, 16'h3FFF, 4'd2},
        {1'b1, 16'h0040, 4'd4},
        {1'b0, 16'h2AAA, 4'd2}
    };

    initial begin
        bit ack;
        logic [7:0] d;
        wt(10);
        chk(sda_oe == 1'b0, "R12 sda_oe reset", sda_oe, 0);
        chk(wr_valid == 1'b0 && wr_stop == 1'b0, "R12 strobes reset", {wr_valid, wr_stop}, 0);
        chk(rd_addr == 16'h0, "R12 pointer reset", rd_addr, 0);
        rst_n = 1'b1;
        wt(20);

        for (int v = 0; v < 5; v++)
            rd_random(VEC[v][20], VEC[v][19:4], int'(VEC[v][3:0]));

        // R1: wrong select and wrong code are not acknowledged
        bus_start(); send_byte(ctl(1'b0, 3'b111, 1'b0), ack); bus_stop();
        chk(!ack, "R1 wrong select", ack, 0);
        bus_start(); send_byte(8'b1001_000_0, ack); bus_stop();
        chk(!ack, "R1 wrong code", ack, 0);

        // R3: busy suppresses ACK, then address-only write to 0x0010
        busy = 1'b1;
        bus_start(); send_byte(ctl(1'b0, 3'b000, 1'b0), ack); bus_stop();
        chk(!ack, "R3 busy no ack", ack, 0);
        busy = 1'b0;
        bus_start(); send_byte(ctl(1'b0, 3'b000, 1'b0), ack);
        chk(ack, "R3 ack after busy", ack, 1);
        send_byte(8'h00, ack); send_byte(8'h10, ack); bus_stop();
        chk(nstop == 0, "R5 no commit address-only", nstop, 0);

        // R11: abort after four bits keeps pointer
        bus_start();
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        chk(sda_oe == 1'b0, "R11 released after abort", sda_oe, 0);
        rd_current(1'b0, 16'h0010, "R11 pointer kept");
        rd_current(1'b0, 16'h0011, "R8 NACK+STOP step");

        // R4/R5: three data bytes crossing page end at 0x013F
        bus_start(); send_byte(ctl(1'b0, 3'b000, 1'b0), ack);
        send_byte(8'h01, ack); send_byte(8'h3E, ack);
        send_byte(8'hA1, ack); chk(ack, "R2 data ack", ack, 1);
        send_byte(8'hB2, ack); send_byte(8'hC3, ack);
        bus_stop();
        chk(nwr == 3, "R4 strobe count", nwr, 3);
        chk(cap_addr[0] == 16'h013E && cap_data[0] == 8'hA1, "R4 byte0", {cap_addr[0], cap_data[0]}, 24'h013EA1);
        chk(cap_addr[1] == 16'h013F && cap_data[1] == 8'hB2, "R4 byte1", {cap_addr[1], cap_data[1]}, 24'h013FB2);
        chk(cap_addr[2] == 16'h0100 && cap_data[2] == 8'hC3, "R4 page wrap", {cap_addr[2], cap_data[2]}, 24'h0100C3);
        chk(cap_sp[0] == 1'b0, "R1 write space", cap_sp[0], 0);
        chk(nstop == 1, "R5 commit on stop", nstop, 1);
        rd_current(1'b0, 16'h0101, "R4 pointer after write");

        // R5/R6: data byte then repeated START, no commit
        bus_start(); send_byte(ctl(1'b0, 3'b000, 1'b0), ack);
        send_byte(8'h02, ack); send_byte(8'h00, ack); send_byte(8'h77, ack);
        bus_start(); send_byte(ctl(1'b0, 3'b000, 1'b1), ack);
        get_byte(1'b0, d);
        chk(d == mdl(1'b0, 16'h0201), "R6 read after rstart", d, mdl(1'b0, 16'h0201));
        bus_stop();
        chk(nstop == 1, "R5 no commit on rstart", nstop, 1);

        // R10: auxiliary read then array current read shares pointer
        rd_random(1'b1, 16'h0401, 1);
        chk(rd_space == 1'b1, "R10 aux space", rd_space, 1);
        rd_current(1'b0, 16'h0402, "R10 shared pointer");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule